// File: doc/BRIEF.md
# Half-Adder Truth-Table Fitness Scorer

This block grades one candidate configuration of a small programmable logic fabric. It has to be told to start. It then walks once through every combination of the two fabric input bits, one combination per clock. For each combination it drives the fabric, captures the two fabric outputs one cycle later and compares them with the expected half-adder response. Every output bit that agrees adds one point to a running score.

When the last captured vector has been scored, the block raises a one-cycle done pulse. At that point the score holds its final value. With four vectors and two outputs per vector the best possible score is 8. A flag marks a candidate that reaches this maximum. The flag stays valid until the next evaluation begins.

The fabric under test sits outside this block, and it is expected to respond combinationally to the drive lines. Any ranking or selection that uses the score also happens outside the block.

Top module: `tt_fitness_eval`

## Requirements
- R1: While reset is held, and directly after it, `score_o` is 0, `done_o` is 0, `perfect_o` is 0 and `fab_drive_o` is 0.
- R2: A start accepted at clock edge E0 makes `fab_drive_o` equal to k during the cycle after edge E0+k, for k = 0 to 3. Bit 0 carries input X and bit 1 carries input Y. Outside those four cycles `fab_drive_o` is 0.
- R3: The expected response to a vector is `fab_out_i[0]` (sum) = X xor Y and `fab_out_i[1]` (carry) = X and Y.
- R4: The final score equals the number of output bits, sum and carry each counted separately over all four vectors, that match R3. It lies between 0 and 8.
- R5: `done_o` is high for exactly one cycle, the cycle after edge E0+5 of an accepted start. `score_o` holds the final score in that cycle.
- R6: `perfect_o` is set together with `done_o` exactly when the final score is 8. It then holds its value until the next accepted start.
- R7: An accepted start clears `score_o` and `perfect_o` at the edge that accepts it.
- R8: A start that arrives while an evaluation is running has no effect: the run keeps its timing and score. A start is accepted when idle, including in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin an evaluation |
| fab_drive_o | output | IN_W (2) | Test vector applied to the fabric, bit 0 = X, bit 1 = Y |
| fab_out_i | input | OUT_W (2) | Fabric response, bit 0 = sum, bit 1 = carry |
| score_o | output | SCORE_W (4) | Count of matching output bits |
| done_o | output | 1 | One-cycle pulse when the score is final |
| perfect_o | output | 1 | Score reached the maximum |

## Verification
The checker keeps its own count of cycles since an accepted start. It assumes that `start_i` only matters when that count is idle or at the done cycle, and that the fabric answers within the same cycle the vector is driven. The bench meets the second assumption with a combinational fabric model whose outputs depend only on `fab_drive_o` and a per-run error mask. It changes that mask only at the moment it issues an accepted start. Stray start pulses in the middle of a run are placed deliberately, so that the ignore rule is exercised while the mask stays fixed.

// File: rtl/tt_fit_pkg.sv
package tt_fit_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } seq_state_e;

   // golden response of a one-bit adder without carry-in: {carry, sum}
   function automatic logic [1:0] half_add_ref(input logic x, input logic y);
      return {x & y, x ^ y};
   endfunction

endpackage

// File: rtl/tt_fit_seq.sv
module tt_fit_seq
   import tt_fit_pkg::*;
#(
   parameter int IN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   output logic [IN_W-1:0] drive_o,
   output logic            sample_o,
   output logic            last_o,
   output logic            clear_o
);
   localparam int NUM_VEC = 1 << IN_W;
   localparam logic [IN_W-1:0] LAST_IDX = IN_W'(NUM_VEC - 1);

   seq_state_e      state_q;
   logic [IN_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (start_i) state_q <= ST_RUN;
            end
            ST_RUN: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) state_q <= ST_DRAIN;
            end
            ST_DRAIN: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign sample_o = (state_q == ST_RUN);
   assign last_o   = sample_o && (idx_q == LAST_IDX);
   assign drive_o  = sample_o ? idx_q : '0;
   assign clear_o  = (state_q == ST_IDLE) && start_i;

endmodule

// File: rtl/tt_fit_cmp.sv
module tt_fit_cmp
   import tt_fit_pkg::*;
#(
   parameter int IN_W  = 2,
   parameter int OUT_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_i,
   input  logic                       last_i,
   input  logic [IN_W-1:0]            drive_i,
   input  logic [OUT_W-1:0]           fab_i,
   output logic                       add_vld_o,
   output logic                       add_last_o,
   output logic [$clog2(OUT_W+1)-1:0] add_cnt_o
);
   localparam int CNT_W = $clog2(OUT_W + 1);

   logic [OUT_W-1:0] exp_w;
   logic [OUT_W-1:0] cap_fab_q;
   logic [OUT_W-1:0] cap_exp_q;
   logic             vld_q;
   logic             last_q;

   generate
      if (OUT_W == 2 && IN_W == 2) begin : g_half_add
         assign exp_w = half_add_ref(drive_i[0], drive_i[1]);
      end else begin : g_no_ref
         assign exp_w = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_fab_q <= '0;
         cap_exp_q <= '0;
         vld_q     <= 1'b0;
         last_q    <= 1'b0;
      end else begin
         vld_q  <= sample_i;
         last_q <= last_i;
         if (sample_i) begin
            cap_fab_q <= fab_i;
            cap_exp_q <= exp_w;
         end
      end
   end

   logic [OUT_W-1:0] hit_w;
   logic [CNT_W-1:0] part_w [OUT_W+1];

   assign hit_w     = ~(cap_fab_q ^ cap_exp_q);
   assign part_w[0] = '0;

   generate
      for (genvar i = 0; i < OUT_W; i++) begin : g_pop
         assign part_w[i+1] = part_w[i] + CNT_W'(hit_w[i]);
      end
   endgenerate

   assign add_vld_o  = vld_q;
   assign add_last_o = last_q;
   assign add_cnt_o  = part_w[OUT_W];

endmodule

// File: rtl/tt_fit_acc.sv
module tt_fit_acc #(
   parameter int SCORE_W   = 4,
   parameter int CNT_W     = 2,
   parameter int MAX_SCORE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               add_vld_i,
   input  logic               add_last_i,
   input  logic [CNT_W-1:0]   add_cnt_i,
   output logic [SCORE_W-1:0] score_o,
   output logic               done_o,
   output logic               perfect_o
);
   logic [SCORE_W-1:0] score_q;
   logic [SCORE_W-1:0] sum_w;
   logic               done_q;
   logic               perf_q;

   assign sum_w = score_q + SCORE_W'(add_cnt_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         score_q <= '0;
         done_q  <= 1'b0;
         perf_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (clear_i) begin
            score_q <= '0;
            perf_q  <= 1'b0;
         end else if (add_vld_i) begin
            score_q <= sum_w;
            if (add_last_i) begin
               done_q <= 1'b1;
               perf_q <= (sum_w == SCORE_W'(MAX_SCORE));
            end
         end
      end
   end

   assign score_o   = score_q;
   assign done_o    = done_q;
   assign perfect_o = perf_q;

endmodule

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval #(
   parameter int IN_W  = 2,
   parameter int OUT_W = 2,
   localparam int NUM_VEC   = 1 << IN_W,
   localparam int MAX_SCORE = NUM_VEC * OUT_W,
   localparam int SCORE_W   = $clog2(MAX_SCORE + 1),
   localparam int CNT_W     = $clog2(OUT_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   output logic [IN_W-1:0]    fab_drive_o,
   input  logic [OUT_W-1:0]   fab_out_i,
   output logic [SCORE_W-1:0] score_o,
   output logic               done_o,
   output logic               perfect_o
);

   generate
      if (IN_W != 2 || OUT_W != 2) begin : g_bad_shape
         $error("tt_fitness_eval: golden table is a half adder, needs IN_W=2 and OUT_W=2");
      end
   endgenerate

   logic             sample_w;
   logic             last_w;
   logic             clear_w;
   logic             add_vld_w;
   logic             add_last_w;
   logic [CNT_W-1:0] add_cnt_w;

   tt_fit_seq #(.IN_W(IN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .drive_o  (fab_drive_o),
      .sample_o (sample_w),
      .last_o   (last_w),
      .clear_o  (clear_w)
   );

   tt_fit_cmp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_i   (sample_w),
      .last_i     (last_w),
      .drive_i    (fab_drive_o),
      .fab_i      (fab_out_i),
      .add_vld_o  (add_vld_w),
      .add_last_o (add_last_w),
      .add_cnt_o  (add_cnt_w)
   );

   tt_fit_acc #(.SCORE_W(SCORE_W), .CNT_W(CNT_W), .MAX_SCORE(MAX_SCORE)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear_w),
      .add_vld_i  (add_vld_w),
      .add_last_i (add_last_w),
      .add_cnt_i  (add_cnt_w),
      .score_o    (score_o),
      .done_o     (done_o),
      .perfect_o  (perfect_o)
   );

endmodule

// File: rtl/tt_fit_chk.sv
module tt_fit_chk #(
   parameter int IN_W  = 2,
   parameter int OUT_W = 2,
   localparam int NUM_VEC   = 1 << IN_W,
   localparam int MAX_SCORE = NUM_VEC * OUT_W,
   localparam int SCORE_W   = $clog2(MAX_SCORE + 1),
   localparam int RUN_W     = $clog2(NUM_VEC + 3),
   localparam int DONE_AT   = NUM_VEC + 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [IN_W-1:0]    fab_drive_o,
   input logic [SCORE_W-1:0] score_o,
   input logic               done_o,
   input logic               perfect_o
);
   logic [RUN_W-1:0] run_q;
   logic             accept_w;

   assign accept_w = start_i && (run_q == '0 || run_q == RUN_W'(DONE_AT));

   always_ff @(posedge clk) begin
      if (!rst_n)                         run_q <= '0;
      else if (accept_w)                  run_q <= RUN_W'(1);
      else if (run_q == RUN_W'(DONE_AT))  run_q <= '0;
      else if (run_q != '0)               run_q <= run_q + 1'b1;
   end

   p_drive_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != '0 && run_q <= RUN_W'(NUM_VEC)) |-> fab_drive_o == IN_W'(run_q - 1'b1));

   p_drive_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == '0 || run_q > RUN_W'(NUM_VEC)) |-> fab_drive_o == '0);

   p_score_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      score_o <= SCORE_W'(MAX_SCORE));

   p_done_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_W'(DONE_AT)) |-> done_o);

   p_done_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> run_q == RUN_W'(DONE_AT));

   p_perfect_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (perfect_o == (score_o == SCORE_W'(MAX_SCORE))));

   p_perfect_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept_w && run_q != RUN_W'(NUM_VEC + 1)) |=> $stable(perfect_o));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept_w |=> (score_o == '0 && !perfect_o));

endmodule

bind tt_fitness_eval tt_fit_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .fab_drive_o (fab_drive_o),
   .score_o     (score_o),
   .done_o      (done_o),
   .perfect_o   (perfect_o)
);

// File: tb/tb_tt_fitness_eval.sv
module tb_tt_fitness_eval;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] fab_drive_o;
   logic [1:0] fab_out_i;
   logic [3:0] score_o;
   logic       done_o;
   logic       perfect_o;

   logic [7:0] err_mask = 8'h00;   // bit v*2+o flips output o for vector v
   int         cyc = 0;
   int         start_cyc = 0;
   int         n_checks = 0;
   int         n_errors = 0;
   bit         finished = 1'b0;
   logic [4:0] exp_q [$];          // {perfect, score}

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // fabric model: correct half adder unless the mask flips a bit
   always_comb begin
      logic x, y;
      x = fab_drive_o[0];
      y = fab_drive_o[1];
      fab_out_i[0] = (x != y) ^ err_mask[{fab_drive_o, 1'b0}];
      fab_out_i[1] = (x && y) ^ err_mask[{fab_drive_o, 1'b1}];
   end

   tt_fitness_eval dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fab_drive_o(fab_drive_o),
      .fab_out_i(fab_out_i), .score_o(score_o), .done_o(done_o), .perfect_o(perfect_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // driver: called at a negedge, returns at the negedge where done is seen
   task automatic run_eval(input logic [7:0] mask, input bit poke_mid);
      int exp_score;
      err_mask  = mask;
      exp_score = 8 - $countones(mask);
      exp_q.push_back({exp_score == 8, 4'(exp_score)});
      start_cyc = cyc;
      start_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(score_o == 0, "R7 score cleared", int'(score_o), 0);
      check(perfect_o == 1'b0, "R7 perfect cleared", int'(perfect_o), 0);
      for (int k = 0; k < 4; k++) begin
         check(fab_drive_o == 2'(k), "R2 vector order", int'(fab_drive_o), k);
         start_i = poke_mid && (k == 1 || k == 3);   // R8 stray starts
         @(negedge clk);
         start_i = 1'b0;
      end
      check(fab_drive_o == 2'd0, "R2 idle drive", int'(fab_drive_o), 0);
      while (!done_o) @(negedge clk);
   endtask

   // monitor: scoreboard compare on every done pulse
   initial begin
      forever begin
         @(negedge clk);
         if (done_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
               logic [4:0] e;
               e = exp_q.pop_front();
               check(score_o == e[3:0], "R4 final score", int'(score_o), int'(e[3:0]));
               check(perfect_o == e[4], "R6 perfect flag", int'(perfect_o), int'(e[4]));
               check(cyc - start_cyc == 6, "R5 R8 done timing", cyc - start_cyc, 6);
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(score_o == 0 && done_o == 0, "R1 reset outputs", int'(score_o) + int'(done_o), 0);
      check(perfect_o == 0 && fab_drive_o == 0, "R1 reset flag/drive",
            int'(perfect_o) + int'(fab_drive_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(score_o == 0 && done_o == 0 && perfect_o == 0, "R1 after reset", int'(score_o), 0);

      run_eval(8'h00, 1'b0);                // R3 correct fabric, 8, perfect
      repeat (3) @(negedge clk);
      check(perfect_o == 1'b1, "R6 perfect held", int'(perfect_o), 1);
      check(score_o == 4'd8, "R4 score held", int'(score_o), 8);
      run_eval(8'h01, 1'b0);                // R3 sum of vector 0 wrong -> 7
      run_eval(8'hFF, 1'b0);                // every bit wrong -> 0 (back to back)
      run_eval(8'hAA, 1'b0);                // carry wrong everywhere -> 4
      run_eval(8'h80, 1'b0);                // carry of X=Y=1 wrong -> 7
      run_eval(8'h00, 1'b1);                // R8 stray starts, still perfect
      run_eval(8'h55, 1'b1);                // R8 sum wrong everywhere -> 4
      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, "R5 all runs completed", exp_q.size(), 0);
      check(fab_drive_o == 2'd0, "R2 idle after runs", int'(fab_drive_o), 0);
      finish_run();
   end

endmodule